// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This unit rounds an unpacked floating-point mantissa to its final width. The incoming mantissa carries two extra low bits (guard, then round) beneath the bit that will become the result's least significant bit. A separate sticky bit summarises everything shifted out below them. Using the sign and a 2-bit rounding-direction field, the unit decides whether to bump the retained bits by one. It then drops the two low bits and reports the outcome.

The increment ripples through the whole retained field into one extra carry bit at the top. A retained field of all ones therefore comes out as a one followed by zeros, the value 2.0. The unit passes that value on as it is: renormalising it, and all exponent handling, is left to the next stage. Inputs are sampled on every rising clock edge and the result appears on registered outputs one cycle later.

Top module: `mant_rounder`

## Requirements
- R1: One clock cycle after inputs are sampled, when no increment occurs, `res_mant` equals `in_mant` shifted right by two (bits [1:0] discarded) with a zero carry bit.
- R2: When guard (`in_mant[1]`), round (`in_mant[0]`) and `sticky` are all zero, no increment occurs and `up`, `inexact` and `frac_up` are all 0.
- R3: `inexact` is 1 exactly when any of guard, round or sticky is 1.
- R4: With `mode` = 2'b00 (nearest, ties to even), an increment occurs only when guard is 1 and at least one of round, sticky or `in_mant[2]` (the retained LSB) is 1.
- R5: With `mode` = 2'b01 (toward zero), no increment ever occurs.
- R6: With `mode` = 2'b10 (toward +infinity), an increment occurs exactly when the result is inexact and `sign` is 0. With `mode` = 2'b11 (toward -infinity), it occurs exactly when the result is inexact and `sign` is 1.
- R7: On an increment, `up` and `frac_up` are both 1 and `res_mant` equals the retained field plus one, with the carry propagated across every bit. Without an increment, both flags are 0.
- R8: A retained field of all ones that is incremented yields `res_mant` with only its top (carry) bit set.
- R9: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_mant | input | FRAC_W+2 | Mantissa; bit 1 is guard, bit 0 is round |
| sticky | input | 1 | OR of all bits below round |
| sign | input | 1 | 1 for a negative value |
| mode | input | 2 | Rounding direction: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| res_mant | output | FRAC_W+1 | Rounded mantissa; the top bit is the carry |
| up | output | 1 | The retained field was incremented |
| inexact | output | 1 | Guard, round or sticky was nonzero |
| frac_up | output | 1 | Fraction-rounded status, set on an increment |

## Verification
On every cycle, the assertions check several rules. An exact input raises no flag. The inexact flag follows the lost bits. Toward-zero mode never increments, and the directed modes never increment against the sign. A zero guard bit blocks the increment in nearest mode. The two increment flags always agree. Without an increment, the mantissa is the input shifted right by two. Whether the increment decision is correct in every case, including ties resolving to even and full carry propagation up to 2.0, is shown by the bench. It sweeps every mantissa, sticky, sign and mode combination at a narrow width against values it computes itself.

// File: rtl/mant_rounder.sv
module mant_rounder #(
  parameter int FRAC_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W+1:0] in_mant,
  input  logic              sticky,
  input  logic              sign,
  input  logic [1:0]        mode,
  output logic [FRAC_W:0]   res_mant,
  output logic              up,
  output logic              inexact,
  output logic              frac_up
);
  localparam int OUT_W = FRAC_W + 1;

  logic [FRAC_W-1:0] kept;
  logic              grd, rnd, lost, bump;
  logic [OUT_W-1:0]  sum;

  assign kept = in_mant[FRAC_W+1:2];
  assign grd  = in_mant[1];
  assign rnd  = in_mant[0];
  assign lost = grd | rnd | sticky;

  always_comb begin
    case (mode)
      2'b01:   bump = 1'b0;
      2'b10:   bump = lost & ~sign;
      2'b11:   bump = lost & sign;
      default: bump = grd & (rnd | sticky | kept[0]);
    endcase
  end

  assign sum = {1'b0, kept} + OUT_W'(bump);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_mant <= '0;
      up       <= 1'b0;
      inexact  <= 1'b0;
      frac_up  <= 1'b0;
    end else begin
      res_mant <= sum;
      up       <= bump;
      inexact  <= lost;
      frac_up  <= bump;
    end
  end
endmodule

// File: rtl/mant_rounder_chk.sv
module mant_rounder_chk #(
  parameter int FRAC_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FRAC_W+1:0] in_mant,
  input logic              sticky,
  input logic              sign,
  input logic [1:0]        mode,
  input logic [FRAC_W:0]   res_mant,
  input logic              up,
  input logic              inexact,
  input logic              frac_up
);
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r2_exact_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(in_mant[1:0] == 2'b00 && !sticky) |-> !up && !inexact && !frac_up);

  a_r3_inexact_follows: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> inexact == $past(|{in_mant[1:0], sticky}));

  a_r4_no_guard_no_bump: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode == 2'b00 && !in_mant[1]) |-> !up);

  a_r5_toward_zero: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode == 2'b01) |-> !up);

  a_r6_plus_neg: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode == 2'b10 && sign) |-> !up);

  a_r6_minus_pos: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(mode == 2'b11 && !sign) |-> !up);

  a_r7_flags_agree: assert property (@(posedge clk) disable iff (!rst_n)
    up == frac_up && (!up || inexact));

  a_r1_shift_only: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !up |-> res_mant == {1'b0, $past(in_mant[FRAC_W+1:2])});
endmodule

bind mant_rounder mant_rounder_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_mant(in_mant), .sticky(sticky), .sign(sign),
  .mode(mode), .res_mant(res_mant), .up(up), .inexact(inexact), .frac_up(frac_up)
);

// File: tb/mant_rounder_bench.sv
module mant_rounder_bench;
  localparam int FW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [FW+1:0] in_mant = '0;
  logic          sticky = 1'b0, sign = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic [FW:0]   res_mant;
  logic          up, inexact, frac_up;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mant_rounder #(.FRAC_W(FW)) u_mant_rounder (
    .clk(clk), .rst_n(rst_n), .in_mant(in_mant), .sticky(sticky), .sign(sign),
    .mode(mode), .res_mant(res_mant), .up(up), .inexact(inexact), .frac_up(frac_up)
  );

  task automatic check(string tag, logic [FW+3:0] got, logic [FW+3:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h (mant=%h st=%b sg=%b md=%b)",
               tag, got, exp, in_mant, sticky, sign, mode);
    end
  endtask

  task automatic apply(int m, bit st, bit sg, bit [1:0] md);
    @(negedge clk);
    in_mant = (FW+2)'(m);
    sticky  = st;
    sign    = sg;
    mode    = md;
    @(negedge clk);
  endtask

  function automatic logic [FW+3:0] model(int m, bit st, bit sg, bit [1:0] md);
    int  keep = m >> 2;
    bit  g = m[1], r = m[0];
    bit  lost = g | r | st;
    bit  inc;
    case (md)
      2'b00: inc = g && (r || st || keep[0]);
      2'b01: inc = 1'b0;
      2'b10: inc = lost && !sg;
      default: inc = lost && sg;
    endcase
    return {(FW+1)'(keep + int'(inc)), inc, lost, inc};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", {res_mant, up, inexact, frac_up}, '0);
    rst_n = 1'b1;

    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++)
        for (int st = 0; st < 2; st++)
          for (int m = 0; m < (1 << (FW + 2)); m++) begin
            string tag;
            apply(m, st[0], sg[0], md[1:0]);
            if (m[1:0] == 2'b00 && st == 0) tag = "R2 exact";
            else if (md == 0) tag = "R4 nearest";
            else if (md == 1) tag = "R5 toward zero";
            else tag = "R6 directed";
            check(tag, {res_mant, up, inexact, frac_up}, model(m, st[0], sg[0], md[1:0]));
          end

    apply(6'b1011_00, 1'b0, 1'b0, 2'b00);
    check("R1 plain shift", {res_mant, up, inexact, frac_up}, {5'b01011, 3'b000});
    apply(6'b0000_01, 1'b0, 1'b1, 2'b01);
    check("R3 round bit alone", {res_mant, up, inexact, frac_up}, {5'b00000, 3'b010});
    apply(6'b0111_10, 1'b1, 1'b0, 2'b00);
    check("R7 carry ripple", {res_mant, up, inexact, frac_up}, {5'b01000, 3'b111});
    apply(6'b1111_11, 1'b0, 1'b0, 2'b00);
    check("R8 nearest to 2.0", {res_mant, up, inexact, frac_up}, {5'b10000, 3'b111});
    apply(6'b1111_00, 1'b1, 1'b1, 2'b11);
    check("R8 minus-inf to 2.0", {res_mant, up, inexact, frac_up}, {5'b10000, 3'b111});
    apply(6'b1111_10, 1'b0, 1'b0, 2'b00);
    check("R4 tie odd rounds up", {res_mant, up, inexact, frac_up}, {5'b10000, 3'b111});
    apply(6'b1110_10, 1'b0, 1'b0, 2'b00);
    check("R4 tie even stays", {res_mant, up, inexact, frac_up}, {5'b01110, 3'b010});

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset again", {res_mant, up, inexact, frac_up}, '0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule